// File: doc/BRIEF.md
# E1 Transmit Path Selector

This block sits between the line encoder and the transmit pulse shaper of one E1 channel. Once per bit period it registers the dual-rail (positive/negative mark) pair that the shaper will turn into a line pulse. The pair can come from the encoder or from recovered receive data that is looped back toward the far end. A maintenance override replaces the stream with continuous marks of alternating polarity.

The bit period is marked by a single-cycle enable from the transmit clock domain. During the override, if the transmit clock is reported invalid, a master-clock enable takes over. The block changes timing source only when the current source completes a bit, so no bit is shortened or stretched. If the current source is the transmit clock and that clock is already dead, the change happens at once.

A second registered pair, the local loopback tap, carries the selected encoder or loopback data without the override. The driver enable combines a dedicated disable pin with a register disable that counts only in host mode. While the driver is off, the line rails are forced to zero at each bit.

Top module: `e1tx_path_sel`

## Requirements
- R1: After reset, both line rails and both tap rails are 0, the driver enable is 1, and the transmit-clock enable times the bits.
- R2: On a bit strobe with the driver on, override off and `sel_remote`=0, the line rails take `enc_p`/`enc_n` on the next clock.
- R3: On a bit strobe with the driver on, override off and `sel_remote`=1, the line rails take `lpbk_p`/`lpbk_n` on the next clock.
- R4: With the override on and the driver on, each bit strobe produces exactly one mark. The first mark of an override episode is on `line_p` (line_p=1, line_n=0). The polarity then alternates on every bit. An episode begins after at least one clock with `all_ones`=0.
- R5: The bit strobe follows `tx_ce` when the transmit clock is the source and `mclk_ce` when the master clock is the source. The master clock is requested only when `all_ones`=1 and `tx_clk_ok`=0. Pulses on the unused enable have no effect.
- R6: The timing source changes only in a cycle where the current source's enable is high. The exception is a source of the transmit clock with `tx_clk_ok`=0, where the change happens on the next clock edge.
- R7: Between bit strobes, the line and tap rails hold their values whatever the data inputs do.
- R8: On each bit strobe, the tap rails take the loopback pair when `sel_remote`=1 and the encoder pair otherwise. The tap ignores the override and the driver disable.
- R9: `drv_en` = NOT(`drv_off_pin` OR (`host_mode` AND `drv_off_reg`)), combinationally.
- R10: Priority is driver off, then the override, then remote loopback, then the encoder. With the driver off, a bit strobe loads 0 into both line rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_ok | input | 1 | Transmit clock reported valid |
| tx_ce | input | 1 | Bit enable from the transmit clock |
| mclk_ce | input | 1 | Bit enable from the master clock |
| enc_p | input | 1 | Encoder positive rail |
| enc_n | input | 1 | Encoder negative rail |
| lpbk_p | input | 1 | Remote loopback positive rail |
| lpbk_n | input | 1 | Remote loopback negative rail |
| sel_remote | input | 1 | Select remote loopback instead of encoder |
| all_ones | input | 1 | Command the all-marks override |
| host_mode | input | 1 | Register controls are honoured |
| drv_off_pin | input | 1 | Dedicated driver disable |
| drv_off_reg | input | 1 | Register driver disable (host mode only) |
| line_p | output | 1 | Positive rail to the pulse shaper |
| line_n | output | 1 | Negative rail to the pulse shaper |
| loop_p | output | 1 | Local loopback tap, positive rail |
| loop_n | output | 1 | Local loopback tap, negative rail |
| drv_en | output | 1 | Line driver enable (0 = high impedance) |

## Verification
On every cycle, the assertions check the following:
- the per-source data transfer on each strobe and the hold between strobes;
- the single mark per override bit and the polarity flip;
- the rule that the timing source moves only at a bit boundary or on a dead transmit clock;
- the driver-enable equation.

Only the bench's scenarios can show the remaining behaviour:
- that the first mark of a new episode is positive;
- that the unused clock enable is truly ignored across a source handover;
- that the tap keeps carrying data while the line shows the override.

The bench also sweeps every combination of data, selection and disable inputs.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

  typedef enum logic [1:0] {
    SRC_ENC    = 2'd0,
    SRC_REMOTE = 2'd1,
    SRC_ONES   = 2'd2,
    SRC_OFF    = 2'd3
  } src_e;

  function automatic logic drv_enable(input logic pin_off, input logic reg_off,
                                      input logic host);
    return !(pin_off || (host && reg_off));
  endfunction

  function automatic src_e pick_src(input logic off, input logic ones,
                                    input logic remote);
    if (off)         return SRC_OFF;
    else if (ones)   return SRC_ONES;
    else if (remote) return SRC_REMOTE;
    else             return SRC_ENC;
  endfunction

  function automatic logic want_master(input logic ones, input logic clk_ok);
    return ones && !clk_ok;
  endfunction

endpackage

// File: rtl/e1tx_bit_timer.sv
module e1tx_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ce,
  input  logic mclk_ce,
  input  logic tx_clk_ok,
  input  logic want_mclk,
  output logic strobe,
  output logic use_mclk
);

  logic swap_ok;

  assign strobe  = use_mclk ? mclk_ce : tx_ce;
  assign swap_ok = strobe || (!use_mclk && !tx_clk_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       use_mclk <= 1'b0;
    else if (swap_ok) use_mclk <= want_mclk;
  end

  // R6: source moves only at a bit boundary or when the transmit clock is dead
  p_src_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_mclk != $past(use_mclk)) |->
      $past(use_mclk ? mclk_ce : (tx_ce || !tx_clk_ok)));

  // R5: a pulse on the unused enable never produces a strobe
  p_unused_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_mclk && !mclk_ce) |-> !strobe);

endmodule

// File: rtl/e1tx_ones_gen.sv
module e1tx_ones_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic episode,
  input  logic active,
  output logic mark_p,
  output logic mark_n
);

  logic pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pol_q <= 1'b0;
    else if (!episode)          pol_q <= 1'b0;
    else if (strobe && active)  pol_q <= !pol_q;
  end

  assign mark_p = !pol_q;
  assign mark_n = pol_q;

  // R4: polarity flips on every emitted mark
  p_pol_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && active && episode) |=> (mark_p != $past(mark_p)));

endmodule

// File: rtl/e1tx_path_sel.sv
module e1tx_path_sel
  import e1tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk_ok,
  input  logic tx_ce,
  input  logic mclk_ce,
  input  logic enc_p,
  input  logic enc_n,
  input  logic lpbk_p,
  input  logic lpbk_n,
  input  logic sel_remote,
  input  logic all_ones,
  input  logic host_mode,
  input  logic drv_off_pin,
  input  logic drv_off_reg,
  output logic line_p,
  output logic line_n,
  output logic loop_p,
  output logic loop_n,
  output logic drv_en
);

  logic strobe, use_mclk, want_mclk;
  logic mark_p, mark_n;
  logic ones_active;
  logic path_p, path_n;
  logic nxt_p, nxt_n;
  src_e src;

  assign drv_en    = drv_enable(drv_off_pin, drv_off_reg, host_mode);
  assign src       = pick_src(!drv_en, all_ones, sel_remote);
  assign want_mclk = want_master(all_ones, tx_clk_ok);
  assign ones_active = (src == SRC_ONES);

  e1tx_bit_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_ce    (tx_ce),
    .mclk_ce  (mclk_ce),
    .tx_clk_ok(tx_clk_ok),
    .want_mclk(want_mclk),
    .strobe   (strobe),
    .use_mclk (use_mclk)
  );

  e1tx_ones_gen u_ones (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .episode(all_ones),
    .active (ones_active),
    .mark_p (mark_p),
    .mark_n (mark_n)
  );

  // data path ahead of the override: feeds the local tap
  assign path_p = sel_remote ? lpbk_p : enc_p;
  assign path_n = sel_remote ? lpbk_n : enc_n;

  always_comb begin
    unique case (src)
      SRC_OFF:  begin nxt_p = 1'b0;   nxt_n = 1'b0;   end
      SRC_ONES: begin nxt_p = mark_p; nxt_n = mark_n; end
      default:  begin nxt_p = path_p; nxt_n = path_n; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= 1'b0;
      line_n <= 1'b0;
      loop_p <= 1'b0;
      loop_n <= 1'b0;
    end else if (strobe) begin
      line_p <= nxt_p;
      line_n <= nxt_n;
      loop_p <= path_p;
      loop_n <= path_n;
    end
  end

  // R2: encoder data reaches the line one clock after a strobe
  p_enc_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && drv_en && !all_ones && !sel_remote) |=>
      (line_p == $past(enc_p) && line_n == $past(enc_n)));

  // R3: remote loopback data reaches the line
  p_remote_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && drv_en && !all_ones && sel_remote) |=>
      (line_p == $past(lpbk_p) && line_n == $past(lpbk_n)));

  // R4: override bits carry exactly one mark
  p_one_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && drv_en && all_ones) |=> ($countones({line_p, line_n}) == 1));

  // R7: rails hold between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(line_p) && $stable(line_n) &&
                 $stable(loop_p) && $stable(loop_n)));

  // R8: tap follows the selected data path, never the override
  p_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (loop_p == $past(sel_remote ? lpbk_p : enc_p) &&
                loop_n == $past(sel_remote ? lpbk_n : enc_n)));

  // R9: driver enable equation
  p_drv_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en == !(drv_off_pin || (host_mode && drv_off_reg)));

  // R10: driver off silences the rails
  p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !drv_en) |=> (!line_p && !line_n));

endmodule

// File: tb/tb_e1tx_path_sel.sv
module tb_e1tx_path_sel;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_clk_ok, tx_ce, mclk_ce;
  logic enc_p, enc_n, lpbk_p, lpbk_n;
  logic sel_remote, all_ones, host_mode, drv_off_pin, drv_off_reg;
  logic line_p, line_n, loop_p, loop_n, drv_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  e1tx_path_sel dut (
    .clk(clk), .rst_n(rst_n), .tx_clk_ok(tx_clk_ok), .tx_ce(tx_ce),
    .mclk_ce(mclk_ce), .enc_p(enc_p), .enc_n(enc_n), .lpbk_p(lpbk_p),
    .lpbk_n(lpbk_n), .sel_remote(sel_remote), .all_ones(all_ones),
    .host_mode(host_mode), .drv_off_pin(drv_off_pin),
    .drv_off_reg(drv_off_reg), .line_p(line_p), .line_n(line_n),
    .loop_p(loop_p), .loop_n(loop_n), .drv_en(drv_en)
  );

  task automatic chk(input string req, input logic [4:0] act,
                     input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock edge with the given enables, then settle at the falling edge
  task automatic tick(input logic t, input logic m);
    tx_ce = t; mclk_ce = m;
    @(posedge clk);
    @(negedge clk);
    tx_ce = 1'b0; mclk_ce = 1'b0;
  endtask

  function automatic logic [1:0] rails();
    return {line_p, line_n};
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_clk_ok = 1; tx_ce = 0; mclk_ce = 0;
    enc_p = 0; enc_n = 0; lpbk_p = 0; lpbk_n = 0;
    sel_remote = 0; all_ones = 0; host_mode = 0;
    drv_off_pin = 0; drv_off_reg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {line_p, line_n, loop_p, loop_n, drv_en}, 5'b00001);

    // exhaustive sweep of data, selection and disable inputs
    for (int v = 0; v < 256; v++) begin
      logic en_e, exp_p, exp_n, tp, tn;
      {enc_p, enc_n, lpbk_p, lpbk_n, sel_remote, host_mode,
       drv_off_pin, drv_off_reg} = v[7:0];
      #1;
      en_e = !(drv_off_pin | (host_mode & drv_off_reg));
      chk("R9", {4'b0, drv_en}, {4'b0, en_e});
      tp = sel_remote ? lpbk_p : enc_p;
      tn = sel_remote ? lpbk_n : enc_n;
      exp_p = en_e ? tp : 1'b0;
      exp_n = en_e ? tn : 1'b0;
      tick(1'b1, 1'b0);
      if (!en_e)           chk("R10", {3'b0, rails()}, {3'b0, exp_p, exp_n});
      else if (sel_remote) chk("R3",  {3'b0, rails()}, {3'b0, exp_p, exp_n});
      else                 chk("R2",  {3'b0, rails()}, {3'b0, exp_p, exp_n});
      chk("R8", {3'b0, loop_p, loop_n}, {3'b0, tp, tn});
      // hold: scramble data, no strobe
      enc_p = ~enc_p; enc_n = ~enc_n; lpbk_p = ~lpbk_p; lpbk_n = ~lpbk_n;
      tick(1'b0, 1'b0);
      chk("R7", {1'b0, line_p, line_n, loop_p, loop_n},
          {1'b0, exp_p, exp_n, tp, tn});
    end
    host_mode = 0; drv_off_pin = 0; drv_off_reg = 0; sel_remote = 0;

    // override with a valid transmit clock
    enc_p = 1; enc_n = 0; all_ones = 1;
    for (int k = 0; k < 6; k++) begin
      tick(1'b1, 1'b0);
      chk("R4", {3'b0, rails()}, (k % 2 == 0) ? 5'b00010 : 5'b00001);
      chk("R8", {3'b0, loop_p, loop_n}, 5'b00010);
    end
    all_ones = 0; enc_p = 0; enc_n = 1;
    tick(1'b1, 1'b0);
    chk("R2", {3'b0, rails()}, 5'b00001);
    all_ones = 1;
    tick(1'b1, 1'b0);
    chk("R4", {3'b0, rails()}, 5'b00010);   // new episode starts positive
    drv_off_pin = 1;
    tick(1'b1, 1'b0);
    chk("R10", {3'b0, rails()}, 5'b00000);
    chk("R8", {3'b0, loop_p, loop_n}, 5'b00001);

    // handover to the master clock
    drv_off_pin = 0; all_ones = 0; enc_p = 1; enc_n = 0;
    tick(1'b1, 1'b0);
    chk("R2", {3'b0, rails()}, 5'b00010);
    all_ones = 1; tx_clk_ok = 0;
    tick(1'b0, 1'b0);                       // dead clock: source moves now
    chk("R6", {3'b0, rails()}, 5'b00010);
    enc_p = 0;
    tick(1'b1, 1'b0);                       // transmit enable ignored
    chk("R5", {3'b0, rails()}, 5'b00010);
    chk("R5", {3'b0, loop_p, loop_n}, 5'b00010);
    tick(1'b0, 1'b1);
    chk("R5", {3'b0, rails()}, 5'b00010);
    tick(1'b0, 1'b1);
    chk("R4", {3'b0, rails()}, 5'b00001);
    tick(1'b0, 1'b1);
    chk("R4", {3'b0, rails()}, 5'b00010);

    // return to the transmit clock only at a master-clock bit
    tx_clk_ok = 1; all_ones = 0; enc_p = 0; enc_n = 1;
    tick(1'b1, 1'b0);
    chk("R6", {3'b0, rails()}, 5'b00010);
    tick(1'b0, 1'b1);
    chk("R6", {3'b0, rails()}, 5'b00001);
    enc_p = 1; enc_n = 1;
    tick(1'b0, 1'b1);
    chk("R6", {3'b0, rails()}, 5'b00001);
    tick(1'b1, 1'b0);
    chk("R5", {3'b0, rails()}, 5'b00011);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule